// File: doc/BRIEF.md
# BCD Time-Match Alarm Controller

This block watches the BCD time fields of a calendar clock and raises an alarm when they agree with a programmed alarm time. Six alarm registers (seconds, minutes, hours, date, month, day of week) each carry an enable in bit 7 and a BCD value in the lower bits laid out like the matching time field. Only enabled fields take part in the comparison, and the comparison is evaluated only on the cycle where the once-per-second update strobe is high.

A match sets a sticky alarm flag and drives an active-low open-drain request line, either as a level that stays low until software clears the flag (latched mode) or as a fixed-length low pulse on every match (repeating mode). A second sticky flag records entry into battery operation. Both flags follow the same rules: software can only clear them, and they can optionally clear themselves when a status read ends. The request line is shared with a frequency output, which wins whenever a frequency is selected, and the line can be switched off entirely while running from the battery.

Top module: `alm_match_ctrl`

## Requirements
- R1: On a clock edge where `sec_tick` and `alarm_en` are 1, at least one field enable is set and every enabled field equals the corresponding time input (compared over the time field's width: 7,7,6,6,5,3 bits for seconds, minutes, hours, date, month, day of week), `alarm_flag` is 1 after that edge.
- R2: Alarm register index 0..5 selects seconds, minutes, hours, date, month, day of week; bit 7 is the field enable and a disabled field never blocks a match; with no field enabled no match ever occurs; indices 6 and 7 write nothing.
- R3: `alarm_flag` never rises on an edge where `sec_tick` was 0, even if the time fields equal the alarm.
- R4: In latched mode (`int_mode`=0) with `fsel`=0, `pin_pull_low` is 1 exactly while `alarm_flag` and `alarm_en` are both 1.
- R5: In repeating mode (`int_mode`=1) with `fsel`=0, each match drives `pin_pull_low` to 1 for exactly PULSE_LEN cycles starting after the matching edge; a new match restarts the pulse.
- R6: A status write (`stat_wr`=1) with bit 0 of `stat_wr_data` at 0 clears `alarm_flag` and with bit 1 at 0 clears `batt_flag`; a bit at 1 leaves its flag unchanged.
- R7: `stat_rd` high marks a status read in progress; on the first cycle it is low again, if `auto_clr` is 1 both flags are cleared; with `auto_clr` at 0 a read leaves the flags unchanged.
- R8: A set event (alarm match or battery entry) that occurs while `stat_rd` is high leaves its flag at 1 after the read ends, even with `auto_clr` at 1.
- R9: A rising edge of `on_battery` sets `batt_flag` on the next clock edge.
- R10: When `fsel` is non-zero and the pin is not disabled, `pin_pull_low` equals the inverse of `fout_in`, overriding the alarm.
- R11: While `on_battery` and `pin_off_batt` are both 1, `pin_pull_low` is 0.
- R12: With `alarm_en` at 0 no match sets `alarm_flag` or starts a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock (32768 Hz in the target system) |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe when the time fields take a new second |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hours, BCD with mode-dependent bit 5 |
| now_date | input | 6 | Current day of month, BCD |
| now_month | input | 5 | Current month, BCD |
| now_wday | input | 3 | Current day of week, 1..7 |
| alm_wr | input | 1 | Alarm register write strobe |
| alm_wr_idx | input | 3 | Alarm register index 0..5 |
| alm_wr_data | input | 8 | Alarm register data: bit 7 enable, low bits BCD value |
| alarm_en | input | 1 | Global alarm enable |
| int_mode | input | 1 | 0 latched level, 1 repeating pulse |
| auto_clr | input | 1 | Clear both flags when a status read ends |
| stat_wr | input | 1 | Status write strobe |
| stat_wr_data | input | 2 | Bit 0 alarm flag, bit 1 battery flag; 0 clears |
| stat_rd | input | 1 | High while a status read is in progress |
| on_battery | input | 1 | Device is running from the backup supply |
| pin_off_batt | input | 1 | Release the request line while on battery |
| fsel | input | 4 | Frequency select; non-zero gives the line to the frequency output |
| fout_in | input | 1 | Selected frequency waveform |
| alarm_flag | output | 1 | Sticky alarm status |
| batt_flag | output | 1 | Sticky battery-entry status |
| pin_pull_low | output | 1 | 1 drives the open-drain request line low |

## Verification
The matcher is driven with every field agreeing, with one enabled field disagreeing, with the disagreeing field disabled and with no field enabled, which separates a correct masked comparison from an unmasked one or one that treats an empty mask as a match. Matching time values held without the second strobe tell an edge-evaluated comparator from a level one. Reads are issued with and without auto-clear and with a match landing inside the read, which distinguishes a clear at read end from a clear at read start or a clear that drops a fresh event. Repeating mode is run with a retrigger inside a pulse, and the shared line is exercised with a toggling frequency and with the battery disable, to show both priority orders.

// File: rtl/alm_pkg.sv
// Shared constants for the BCD time-match alarm controller.
// Assumes six alarm fields in the fixed order seconds..day of week.
package alm_pkg;
    localparam int NFIELD = 6;
    localparam int REG_W  = 8;
    localparam int IDX_W  = 3;

    typedef enum logic [2:0] {
        F_SEC   = 3'd0,
        F_MIN   = 3'd1,
        F_HOUR  = 3'd2,
        F_DATE  = 3'd3,
        F_MONTH = 3'd4,
        F_WDAY  = 3'd5
    } field_e;

    // Width of the BCD time field with the given index.
    function automatic int field_width(input int idx);
        case (idx)
            0, 1:    return 7;
            2, 3:    return 6;
            4:       return 5;
            default: return 3;
        endcase
    endfunction
endpackage

// File: rtl/alm_field_cmp.sv
// One masked field comparator.
// Assumes cfg bit 7 is the enable and cfg[W-1:0] holds the BCD value.
module alm_field_cmp #(
    parameter int W = 7
) (
    input  logic [7:0] cfg,
    input  logic [7:0] now_val,
    output logic       used,
    output logic       agree
);
    // A disabled field agrees unconditionally; an enabled one compares W bits.
    always_comb begin
        used  = cfg[7];
        agree = !cfg[7] || (cfg[W-1:0] == now_val[W-1:0]);
    end
endmodule

// File: rtl/alm_sticky_flag.sv
// Status flag that software may only clear, with optional clear at read end.
// Assumes rd_end is a one-cycle pulse on the first cycle after a read.
// A set event always wins; an event seen during a read survives its end.
module alm_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic rd_active,
    input  logic rd_end,
    input  logic auto_clr,
    output logic flag
);
    logic seen_in_rd;
    logic flag_nx;

    // Next flag value from write, read-end and set priorities.
    always_comb begin
        flag_nx = flag;
        if (wr_en && !wr_bit)
            flag_nx = 1'b0;
        if (rd_end && auto_clr && !seen_in_rd)
            flag_nx = 1'b0;
        if (set_ev)
            flag_nx = 1'b1;
    end

    // Register the flag and remember events inside the current read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag       <= 1'b0;
            seen_in_rd <= 1'b0;
        end else begin
            flag       <= flag_nx;
            seen_in_rd <= rd_active ? (seen_in_rd | set_ev) : 1'b0;
        end
    end
endmodule

// File: rtl/alm_pulse.sv
// Fixed-length pulse generator for the repeating alarm mode.
// Assumes load is a single-cycle strobe; a load restarts the count.
module alm_pulse #(
    parameter int LEN = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic active
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LEN_V = CW'(LEN);

    logic [CW-1:0] cnt;

    // Load on a match, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= LEN_V;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // The pulse is active while the count is non-zero.
    always_comb active = (cnt != '0);
endmodule

// File: rtl/alm_match_ctrl.sv
// BCD time-match alarm controller top.
// Compares the time fields with six enabled alarm registers once per
// second, keeps the alarm and battery status flags and drives the shared
// open-drain request line. Assumes all inputs are synchronous to clk.
module alm_match_ctrl
    import alm_pkg::*;
#(
    parameter int PULSE_LEN = 8192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic [6:0]       now_sec,
    input  logic [6:0]       now_min,
    input  logic [5:0]       now_hour,
    input  logic [5:0]       now_date,
    input  logic [4:0]       now_month,
    input  logic [2:0]       now_wday,
    input  logic             alm_wr,
    input  logic [IDX_W-1:0] alm_wr_idx,
    input  logic [REG_W-1:0] alm_wr_data,
    input  logic             alarm_en,
    input  logic             int_mode,
    input  logic             auto_clr,
    input  logic             stat_wr,
    input  logic [1:0]       stat_wr_data,
    input  logic             stat_rd,
    input  logic             on_battery,
    input  logic             pin_off_batt,
    input  logic [3:0]       fsel,
    input  logic             fout_in,
    output logic             alarm_flag,
    output logic             batt_flag,
    output logic             pin_pull_low
);
    logic [REG_W-1:0] alm_reg [NFIELD];
    logic [7:0]       tf      [NFIELD];
    logic [NFIELD-1:0] f_used;
    logic [NFIELD-1:0] f_agree;
    logic match;
    logic rd_q, rd_end;
    logic batt_q, batt_rise;
    logic pulse_on;
    logic pin_gated;

    // Widen each time field to a common byte for the comparators.
    always_comb begin
        tf[F_SEC]   = {1'b0, now_sec};
        tf[F_MIN]   = {1'b0, now_min};
        tf[F_HOUR]  = {2'b0, now_hour};
        tf[F_DATE]  = {2'b0, now_date};
        tf[F_MONTH] = {3'b0, now_month};
        tf[F_WDAY]  = {5'b0, now_wday};
    end

    // Alarm register file and one comparator per field.
    for (genvar i = 0; i < NFIELD; i++) begin : g_field
        always_ff @(posedge clk) begin
            if (!rst_n)
                alm_reg[i] <= '0;
            else if (alm_wr && (alm_wr_idx == IDX_W'(i)))
                alm_reg[i] <= alm_wr_data;
        end

        alm_field_cmp #(.W(field_width(i))) u_cmp (
            .cfg     (alm_reg[i]),
            .now_val (tf[i]),
            .used    (f_used[i]),
            .agree   (f_agree[i])
        );
    end

    // A match needs the strobe, the global enable and at least one field.
    always_comb match = sec_tick && alarm_en && (|f_used) && (&f_agree);

    // Track read end and battery entry edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            batt_q <= 1'b0;
        end else begin
            rd_q   <= stat_rd;
            batt_q <= on_battery;
        end
    end

    always_comb begin
        rd_end    = rd_q && !stat_rd;
        batt_rise = on_battery && !batt_q;
    end

    alm_sticky_flag u_alarm_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_ev    (match),
        .wr_en     (stat_wr),
        .wr_bit    (stat_wr_data[0]),
        .rd_active (stat_rd),
        .rd_end    (rd_end),
        .auto_clr  (auto_clr),
        .flag      (alarm_flag)
    );

    alm_sticky_flag u_batt_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_ev    (batt_rise),
        .wr_en     (stat_wr),
        .wr_bit    (stat_wr_data[1]),
        .rd_active (stat_rd),
        .rd_end    (rd_end),
        .auto_clr  (auto_clr),
        .flag      (batt_flag)
    );

    alm_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (match && int_mode),
        .active (pulse_on)
    );

    // Line source: battery disable, then frequency, then alarm mode.
    always_comb begin
        pin_gated = on_battery && pin_off_batt;
        if (pin_gated)
            pin_pull_low = 1'b0;
        else if (fsel != 4'd0)
            pin_pull_low = !fout_in;
        else if (int_mode)
            pin_pull_low = pulse_on;
        else
            pin_pull_low = alarm_flag && alarm_en;
    end
endmodule

// File: rtl/alm_match_ctrl_chk.sv
// Property checker for alm_match_ctrl, attached by bind below.
// Relates ports over time; assumes synchronous active-low reset.
module alm_match_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic       alarm_en,
    input logic       int_mode,
    input logic       stat_wr,
    input logic [1:0] stat_wr_data,
    input logic       stat_rd,
    input logic       on_battery,
    input logic       pin_off_batt,
    input logic [3:0] fsel,
    input logic       fout_in,
    input logic       alarm_flag,
    input logic       batt_flag,
    input logic       pin_pull_low
);
    logic past_ok;

    // Marks cycles that have a valid previous cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_flag_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(alarm_flag)) |-> ($past(sec_tick) && $past(alarm_en)));

    assert_write_one_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && stat_wr_data[0] && alarm_flag && stat_rd) |=> alarm_flag);

    assert_latched_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_mode && fsel == 4'd0 && !(on_battery && pin_off_batt))
            |-> (pin_pull_low == (alarm_flag && alarm_en)));

    assert_freq_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel != 4'd0 && !(on_battery && pin_off_batt)) |-> (pin_pull_low == !fout_in));

    assert_batt_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (on_battery && pin_off_batt) |-> !pin_pull_low);

    assert_batt_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(on_battery)) |=> batt_flag);
endmodule

bind alm_match_ctrl alm_match_ctrl_chk u_chk (.*);

// File: tb/alm_match_ctrl_tb.sv
// Self-checking bench with a behavioural reference model compared every cycle.
module alm_match_ctrl_tb;
    localparam int PL = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_tick = 0;
    logic [6:0] now_sec = 0, now_min = 0;
    logic [5:0] now_hour = 0, now_date = 0;
    logic [4:0] now_month = 0;
    logic [2:0] now_wday = 0;
    logic alm_wr = 0;
    logic [2:0] alm_wr_idx = 0;
    logic [7:0] alm_wr_data = 0;
    logic alarm_en = 0, int_mode = 0, auto_clr = 0;
    logic stat_wr = 0;
    logic [1:0] stat_wr_data = 2'b11;
    logic stat_rd = 0, on_battery = 0, pin_off_batt = 0;
    logic [3:0] fsel = 0;
    logic fout_in = 0;
    logic alarm_flag, batt_flag, pin_pull_low;

    int n_checks = 0;
    int n_fail = 0;
    string phase = "R0";

    always #10 clk = ~clk;

    alm_match_ctrl #(.PULSE_LEN(PL)) u_dut (.*);

    // Reference model state
    int  m_en  [6];
    int  m_val [6];
    bit  m_flag, m_batt, m_hit, m_bhit, m_rdq, m_bprev;
    int  m_cnt;

    function automatic int fmask(int i);
        case (i)
            0, 1: return 127;
            2, 3: return 63;
            4:    return 31;
            default: return 7;
        endcase
    endfunction

    function automatic int tval(int i);
        case (i)
            0: return int'(now_sec);
            1: return int'(now_min);
            2: return int'(now_hour);
            3: return int'(now_date);
            4: return int'(now_month);
            default: return int'(now_wday);
        endcase
    endfunction

    // Reference model: next state from the inputs sampled at the edge.
    always @(posedge clk) begin
        bit any_en, all_eq, match, brise, rend, nf, nb;
        if (!rst_n) begin
            for (int i = 0; i < 6; i++) begin m_en[i] = 0; m_val[i] = 0; end
            m_flag = 0; m_batt = 0; m_hit = 0; m_bhit = 0;
            m_rdq = 0; m_bprev = 0; m_cnt = 0;
        end else begin
            any_en = 0; all_eq = 1;
            for (int i = 0; i < 6; i++)
                if (m_en[i] != 0) begin
                    any_en = 1;
                    if (m_val[i] != (tval(i) & fmask(i))) all_eq = 0;
                end
            match = sec_tick && alarm_en && any_en && all_eq;
            brise = on_battery && !m_bprev;
            rend  = !stat_rd && m_rdq;
            nf = m_flag; nb = m_batt;
            if (stat_wr && !stat_wr_data[0]) nf = 0;
            if (stat_wr && !stat_wr_data[1]) nb = 0;
            if (rend && auto_clr && !m_hit)  nf = 0;
            if (rend && auto_clr && !m_bhit) nb = 0;
            if (match) nf = 1;
            if (brise) nb = 1;
            m_hit  = stat_rd ? (m_hit | match) : 0;
            m_bhit = stat_rd ? (m_bhit | brise) : 0;
            m_flag = nf; m_batt = nb;
            if (match && int_mode) m_cnt = PL;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
            if (alm_wr && alm_wr_idx < 6) begin
                m_en[alm_wr_idx]  = alm_wr_data[7];
                m_val[alm_wr_idx] = int'(alm_wr_data[6:0]) & fmask(int'(alm_wr_idx));
            end
            m_rdq = stat_rd; m_bprev = on_battery;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every cycle against the model, away from the active edge.
    always @(negedge clk) begin
        bit ep;
        if (rst_n) begin
            if (on_battery && pin_off_batt) ep = 0;
            else if (fsel != 0)             ep = !fout_in;
            else if (int_mode)              ep = (m_cnt != 0);
            else                            ep = m_flag && alarm_en;
            check({phase, " model alarm_flag"}, int'(alarm_flag), int'(m_flag));
            check({phase, " model batt_flag"}, int'(batt_flag), int'(m_batt));
            check({phase, " model pin_pull_low"}, int'(pin_pull_low), int'(ep));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr_alarm(input int idx, input int data);
        alm_wr = 1; alm_wr_idx = 3'(idx); alm_wr_data = 8'(data);
        cyc(1);
        alm_wr = 0;
    endtask

    task automatic tick();
        sec_tick = 1; cyc(1); sec_tick = 0;
    endtask

    task automatic stat_write(input int d);
        stat_wr = 1; stat_wr_data = 2'(d); cyc(1);
        stat_wr = 0; stat_wr_data = 2'b11;
    endtask

    task automatic clear_all();
        for (int i = 0; i < 8; i++) wr_alarm(i, 0);
        stat_write(0);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1; cyc(1);
        phase = "R0";
        check("R0 reset alarm_flag", int'(alarm_flag), 0);
        check("R0 reset pin", int'(pin_pull_low), 0);

        // R1 basic seconds match, latched mode
        phase = "R1";
        alarm_en = 1;
        wr_alarm(0, 8'hB0);          // enable, sec 30
        now_sec = 7'h30; now_min = 7'h12;
        tick();
        check("R1 flag after match", int'(alarm_flag), 1);
        phase = "R4";
        check("R4 latched level", int'(pin_pull_low), 1);
        cyc(5);
        check("R4 still low", int'(pin_pull_low), 1);

        // R6 write-one keeps, write-zero clears
        phase = "R6";
        stat_write(2'b11);
        check("R6 write one keeps", int'(alarm_flag), 1);
        stat_write(2'b10);
        check("R6 write zero clears", int'(alarm_flag), 0);
        check("R4 released after clear", int'(pin_pull_low), 0);

        // R2 masked comparison
        phase = "R2";
        wr_alarm(1, 8'h95);          // enable, min 15
        now_min = 7'h14;
        tick();
        check("R2 enabled mismatch blocks", int'(alarm_flag), 0);
        wr_alarm(1, 8'h15);          // min disabled, value still differs
        tick();
        check("R2 disabled field ignored", int'(alarm_flag), 1);
        stat_write(0);
        wr_alarm(0, 8'h30);          // nothing enabled
        tick();
        check("R2 no enabled field no match", int'(alarm_flag), 0);
        wr_alarm(6, 8'hB0); wr_alarm(7, 8'hB0);
        tick();
        check("R2 index 6/7 ignored", int'(alarm_flag), 0);
        wr_alarm(5, 8'h83);          // day of week 3
        now_wday = 3'd3; wr_alarm(2, 8'hA7); now_hour = 6'h27;
        tick();
        check("R2 hour and wday match", int'(alarm_flag), 1);
        clear_all();

        // R12 global enable off
        phase = "R12";
        wr_alarm(0, 8'hB0);
        alarm_en = 0;
        tick();
        check("R12 disabled no flag", int'(alarm_flag), 0);
        alarm_en = 1;

        // R3 no strobe, no match
        phase = "R3";
        cyc(10);
        check("R3 no tick no flag", int'(alarm_flag), 0);

        // R5 repeating pulse
        phase = "R5";
        int_mode = 1;
        tick();
        check("R5 pulse starts", int'(pin_pull_low), 1);
        check("R5 flag set", int'(alarm_flag), 1);
        cyc(PL - 1);
        check("R5 pulse last cycle", int'(pin_pull_low), 1);
        cyc(1);
        check("R5 pulse ended", int'(pin_pull_low), 0);
        tick();
        cyc(PL / 2);
        tick();
        cyc(PL - 1);
        check("R5 retrigger extends", int'(pin_pull_low), 1);
        cyc(1);
        check("R5 retrigger end", int'(pin_pull_low), 0);
        int_mode = 0;
        stat_write(0);

        // R7 clear on read end
        phase = "R7";
        tick();
        auto_clr = 0;
        stat_rd = 1; cyc(2); stat_rd = 0; cyc(2);
        check("R7 no auto clear keeps", int'(alarm_flag), 1);
        auto_clr = 1;
        stat_rd = 1; cyc(2);
        check("R7 held during read", int'(alarm_flag), 1);
        stat_rd = 0; cyc(1);
        check("R7 cleared at read end", int'(alarm_flag), 0);

        // R8 match during read survives
        phase = "R8";
        stat_rd = 1; cyc(1);
        tick();
        cyc(1);
        stat_rd = 0; cyc(2);
        check("R8 match in read kept", int'(alarm_flag), 1);
        stat_write(0);

        // R9 battery flag
        phase = "R9";
        on_battery = 1; cyc(1);
        check("R9 batt flag set", int'(batt_flag), 1);
        stat_rd = 1; cyc(1); stat_rd = 0; cyc(1);
        check("R9 batt auto cleared", int'(batt_flag), 0);
        on_battery = 0; cyc(1);
        on_battery = 1; cyc(1); on_battery = 0;
        auto_clr = 0;
        stat_write(2'b01);
        check("R9 batt write zero", int'(batt_flag), 0);

        // R10 frequency priority
        phase = "R10";
        tick();
        fsel = 4'd3;
        for (int k = 0; k < 6; k++) begin
            fout_in = ~fout_in; cyc(1);
            check("R10 follows frequency", int'(pin_pull_low), int'(!fout_in));
        end
        fsel = 0; fout_in = 0; cyc(1);
        check("R10 back to alarm", int'(pin_pull_low), 1);

        // R11 battery disable
        phase = "R11";
        pin_off_batt = 1; on_battery = 1; cyc(1);
        check("R11 released on battery", int'(pin_pull_low), 0);
        fsel = 4'd5; cyc(2);
        check("R11 released over frequency", int'(pin_pull_low), 0);
        on_battery = 0; fsel = 0; cyc(1);
        check("R11 restored", int'(pin_pull_low), 1);

        cyc(3);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule